// File: doc/BRIEF.md
# Motor Driver Power Supervisor

This block supervises the power state of a two-bridge stepper motor driver. It takes the active-low enable and active-low sleep pins, three fault flags (die overtemperature, charge-pump undervoltage and internal regulator fault) and the power-on undervoltage lockout. From these it produces four outputs: the bridge output enable, a one-cycle home pulse that returns the microstep translator to its home position, a power-down request for the analog subsystems, and a step-ready flag. The step-ready flag gates the incoming step pulses before they reach the translator.

All asynchronous inputs pass through two-flop synchronizers. A four-state machine (lockout, sleep, wake, run) tracks the power state. Each entry into the wake state issues a home pulse and starts a timer of `WAKE_US` microseconds, counted at `CLK_HZ`. The translator accepts step pulses only after that timer expires. The enable pin and the fault flags act only on the bridge outputs. They never disturb the sequencing state or the step path, so a fault that clears lets the outputs return at once, with no new wake-up.

Top module: `mdrv_pwr_sup`

## Requirements
- R1: Two cycles after `en_ni` goes high, `bridge_en_o` is 0. Two cycles after `en_ni` returns low, `bridge_en_o` is 1 again, provided the block is in the wake or run state and no fault is present.
- R2: The level of `en_ni` has no effect on `step_ready_o` or on the passing of step pulses.
- R3: Two cycles after `ot_fault_i` or `cp_uv_i` goes high, `bridge_en_o` is 0. Two cycles after the flag clears, `bridge_en_o` is 1 again, with no home pulse, and `step_ready_o` stays 1 throughout.
- R4: `reg_fault_i` gates `bridge_en_o` with the same timing as R3, again with no home pulse and no loss of step readiness.
- R5: Three cycles after `uvlo_i` goes high, `analog_off_o` is 1 and both `bridge_en_o` and `step_ready_o` are 0. If sleep is not requested when the lockout releases, a single home pulse appears 3 cycles after the release, and `bridge_en_o` rises in that same cycle.
- R6: Three cycles after `sleep_ni` goes low, `analog_off_o` is 1, `bridge_en_o` is 0 and `step_ready_o` is 0. Step pulses are dropped while asleep.
- R7: When `sleep_ni` goes high, a single-cycle home pulse appears on `home_rst_o` 3 cycles later. `step_ready_o` rises exactly `CLK_HZ/1e6*WAKE_US` cycles after that pulse.
- R8: A rising edge on `step_i` produces a one-cycle pulse on `step_o` 2 cycles later, but only when `step_ready_o` is 1 in that cycle. Edges that arrive before the wake delay ends are dropped.
- R9: If sleep is requested again during the wake delay, the block returns to sleep. The next sleep exit issues a new home pulse and restarts the full delay.
- R10: While `rst_ni` is low, `bridge_en_o`, `home_rst_o` and `step_ready_o` are 0 and `analog_off_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_ni | input | 1 | Active-low bridge output enable pin |
| sleep_ni | input | 1 | Active-low sleep pin |
| ot_fault_i | input | 1 | Overtemperature fault flag |
| cp_uv_i | input | 1 | Charge-pump undervoltage flag |
| reg_fault_i | input | 1 | Internal regulator fault flag |
| uvlo_i | input | 1 | Power-on undervoltage lockout |
| step_i | input | 1 | Raw step command input |
| bridge_en_o | output | 1 | Enables the bridge power stages |
| home_rst_o | output | 1 | One-cycle translator home pulse |
| analog_off_o | output | 1 | Power-down request for charge pump and regulator |
| step_ready_o | output | 1 | Step commands are accepted |
| step_o | output | 1 | Gated step pulse toward the translator |

## Verification
The bench exercises the power sequence in four ways: lockout release, sleep entry and exit, a sleep request interrupting an unfinished wake delay, and a lockout that reasserts while running. These show whether each path issues its own home pulse and restarts the delay. Each step pulse is tried inside the wake window, after it, while asleep and while the enable pin is high. Together these separate the gating of steps by readiness from any gating by enable. Toggling each fault flag while running shows that faults act only on the bridge output. A clearing fault must bring no home pulse and no drop in readiness.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;

  typedef enum logic [1:0] {
    PS_LOCK  = 2'd0,
    PS_SLEEP = 2'd1,
    PS_WAKE  = 2'd2,
    PS_RUN   = 2'd3
  } pstate_e;

  // synchronizer lane assignment
  localparam int unsigned SY_EN   = 0;
  localparam int unsigned SY_SLP  = 1;
  localparam int unsigned SY_OT   = 2;
  localparam int unsigned SY_CP   = 3;
  localparam int unsigned SY_REG  = 4;
  localparam int unsigned SY_UVLO = 5;
  localparam int unsigned SY_STEP = 6;
  localparam int unsigned SY_NUM  = 7;

  // safe values while in reset: disabled, asleep, faulted, locked out, no step
  localparam logic [SY_NUM-1:0] SY_RST = 7'b0111101;

  function automatic int unsigned wake_cycles(int unsigned clk_hz, int unsigned wake_us);
    int unsigned c;
    c = (clk_hz / 1_000_000) * wake_us;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/mdrv_sync.sv
module mdrv_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/mdrv_wake_timer.sv
module mdrv_wake_timer #(
  parameter int unsigned CYCLES = 50_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD_VAL;
    end else if (load_i) begin
      cnt_q <= LOAD_VAL;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/mdrv_step_gate.sv
module mdrv_step_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_s_i,
  input  logic ready_i,
  output logic step_o
);

  logic step_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_d_q <= 1'b0;
    else         step_d_q <= step_s_i;
  end

  // edges seen while not ready are discarded, not deferred
  assign step_o = step_s_i & ~step_d_q & ready_i;

endmodule

// File: rtl/mdrv_pwr_sup.sv
module mdrv_pwr_sup
  import mdrv_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned WAKE_US = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  input  logic sleep_ni,
  input  logic ot_fault_i,
  input  logic cp_uv_i,
  input  logic reg_fault_i,
  input  logic uvlo_i,
  input  logic step_i,
  output logic bridge_en_o,
  output logic home_rst_o,
  output logic analog_off_o,
  output logic step_ready_o,
  output logic step_o
);

  localparam int unsigned WAKE_CYC = wake_cycles(CLK_HZ, WAKE_US);

  logic [SY_NUM-1:0] raw;
  logic [SY_NUM-1:0] syn;

  always_comb begin
    raw          = '0;
    raw[SY_EN]   = en_ni;
    raw[SY_SLP]  = sleep_ni;
    raw[SY_OT]   = ot_fault_i;
    raw[SY_CP]   = cp_uv_i;
    raw[SY_REG]  = reg_fault_i;
    raw[SY_UVLO] = uvlo_i;
    raw[SY_STEP] = step_i;
  end

  mdrv_sync #(
    .W      (SY_NUM),
    .RST_VAL(SY_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  logic en_off;
  logic sleeping;
  logic fault_any;
  logic uvlo_s;

  assign en_off    = syn[SY_EN];
  assign sleeping  = ~syn[SY_SLP];
  assign fault_any = syn[SY_OT] | syn[SY_CP] | syn[SY_REG];
  assign uvlo_s    = syn[SY_UVLO];

  pstate_e st_q, st_d;
  logic    home_d, home_q;
  logic    wake_load;
  logic    wake_done;

  always_comb begin
    st_d      = st_q;
    home_d    = 1'b0;
    wake_load = 1'b0;
    if (uvlo_s) begin
      st_d = PS_LOCK;
    end else begin
      unique case (st_q)
        PS_LOCK: begin
          if (sleeping) begin
            st_d = PS_SLEEP;
          end else begin
            st_d      = PS_WAKE;
            home_d    = 1'b1;
            wake_load = 1'b1;
          end
        end
        PS_SLEEP: begin
          if (!sleeping) begin
            st_d      = PS_WAKE;
            home_d    = 1'b1;
            wake_load = 1'b1;
          end
        end
        PS_WAKE: begin
          if (sleeping)       st_d = PS_SLEEP;
          else if (wake_done) st_d = PS_RUN;
        end
        PS_RUN: begin
          if (sleeping) st_d = PS_SLEEP;
        end
        default: st_d = PS_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_LOCK;
      home_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      home_q <= home_d;
    end
  end

  mdrv_wake_timer #(
    .CYCLES(WAKE_CYC)
  ) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wake_load),
    .run_i (st_q == PS_WAKE),
    .done_o(wake_done)
  );

  logic powered;
  assign powered = (st_q == PS_WAKE) || (st_q == PS_RUN);

  assign bridge_en_o  = powered & ~en_off & ~fault_any;
  assign home_rst_o   = home_q;
  assign analog_off_o = ~powered;
  assign step_ready_o = (st_q == PS_RUN);

  mdrv_step_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_s_i(syn[SY_STEP]),
    .ready_i (step_ready_o),
    .step_o  (step_o)
  );

endmodule

// File: rtl/mdrv_pwr_sup_chk.sv
module mdrv_pwr_sup_chk
  import mdrv_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    en_off,
  input logic    fault_any,
  input logic    uvlo_s,
  input logic    wake_done,
  input pstate_e st_q,
  input logic    bridge_en_o,
  input logic    home_rst_o,
  input logic    analog_off_o,
  input logic    step_ready_o,
  input logic    step_o
);

  a_r1_enable_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_off |-> !bridge_en_o);

  a_r3_fault_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_any |-> !bridge_en_o);

  a_r5_lockout_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_s |=> analog_off_o && !step_ready_o);

  a_r6_off_means_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    analog_off_o |-> !bridge_en_o && !step_ready_o);

  a_r7_home_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    home_rst_o |=> !home_rst_o);

  a_r7_ready_after_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_ready_o) |-> $past(wake_done) && $past(st_q) == PS_WAKE);

  a_r8_step_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> step_ready_o);

  a_r9_home_restarts_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    home_rst_o |-> !step_ready_o);

endmodule

bind mdrv_pwr_sup mdrv_pwr_sup_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_off      (en_off),
  .fault_any   (fault_any),
  .uvlo_s      (uvlo_s),
  .wake_done   (wake_done),
  .st_q        (st_q),
  .bridge_en_o (bridge_en_o),
  .home_rst_o  (home_rst_o),
  .analog_off_o(analog_off_o),
  .step_ready_o(step_ready_o),
  .step_o      (step_o)
);

// File: tb/mdrv_pwr_sup_tb.sv
module mdrv_pwr_sup_tb;

  localparam int W = 100;  // 50 MHz, 2 us

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b0, sleep_n = 1'b1, ot = 1'b0, cp = 1'b0, rf = 1'b0, uvlo = 1'b1, step = 1'b0;
  logic bridge_en, home_rst, analog_off, step_ready, step_out;

  always #10 clk = ~clk;

  mdrv_pwr_sup #(.CLK_HZ(50_000_000), .WAKE_US(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_ni(en_n), .sleep_ni(sleep_n),
    .ot_fault_i(ot), .cp_uv_i(cp), .reg_fault_i(rf), .uvlo_i(uvlo), .step_i(step),
    .bridge_en_o(bridge_en), .home_rst_o(home_rst), .analog_off_o(analog_off),
    .step_ready_o(step_ready), .step_o(step_out)
  );

  typedef struct { int kind; int at; string req; } ev_t;  // kind 0 home, 1 step
  ev_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: cycle %0d got %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  // scoreboard monitor
  task automatic got(int kind);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL R5/R7/R8 unexpected event: got kind %0d at %0d expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        failures++;
        $display("FAIL %s: got kind %0d at %0d expected kind %0d at %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (home_rst) got(0);
      if (step_out) got(1);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(int kind, int at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic send_step(bit pass, string req);
    int n;
    @(negedge clk);
    n = cyc;
    step = 1'b1;
    if (pass) push(1, n + 2, req);
    tick(3);
    step = 1'b0;
    tick(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n, m;
    tick(4);
    check("R10 bridge", bridge_en, 1'b0);
    check("R10 home", home_rst, 1'b0);
    check("R10 analog", analog_off, 1'b1);
    check("R10 ready", step_ready, 1'b0);
    rst_n = 1'b1;
    tick(6);
    check("R5 locked analog", analog_off, 1'b1);
    check("R5 locked bridge", bridge_en, 1'b0);

    // lockout release
    @(negedge clk); n = cyc; uvlo = 1'b0; push(0, n + 3, "R5 home on release");
    wait_cyc(n + 2); check("R5 bridge before", bridge_en, 1'b0);
    wait_cyc(n + 3); check("R5 bridge after", bridge_en, 1'b1);
    wait_cyc(n + 10);
    send_step(0, "R8 drop in wake");
    wait_cyc(n + 2 + W); check("R7 ready early", step_ready, 1'b0);
    wait_cyc(n + 3 + W); check("R7 ready on time", step_ready, 1'b1);
    send_step(1, "R8 pass");
    send_step(1, "R8 pass again");

    // enable gates outputs only
    @(negedge clk); n = cyc; en_n = 1'b1;
    wait_cyc(n + 1); check("R1 bridge hold", bridge_en, 1'b1);
    wait_cyc(n + 2); check("R1 bridge off", bridge_en, 1'b0);
    send_step(1, "R2 step with enable high");
    check("R2 ready with enable high", step_ready, 1'b1);
    @(negedge clk); n = cyc; en_n = 1'b0;
    wait_cyc(n + 2); check("R1 bridge back", bridge_en, 1'b1);

    // faults
    @(negedge clk); n = cyc; ot = 1'b1;
    wait_cyc(n + 2); check("R3 ot off", bridge_en, 1'b0); check("R3 ot ready", step_ready, 1'b1);
    @(negedge clk); n = cyc; ot = 1'b0;
    wait_cyc(n + 2); check("R3 ot recover", bridge_en, 1'b1); check("R3 ot ready kept", step_ready, 1'b1);
    @(negedge clk); n = cyc; cp = 1'b1;
    wait_cyc(n + 2); check("R3 cp off", bridge_en, 1'b0);
    @(negedge clk); n = cyc; cp = 1'b0;
    wait_cyc(n + 2); check("R3 cp recover", bridge_en, 1'b1);
    @(negedge clk); n = cyc; rf = 1'b1;
    wait_cyc(n + 1); check("R4 reg hold", bridge_en, 1'b1);
    wait_cyc(n + 2); check("R4 reg off", bridge_en, 1'b0); check("R4 reg ready", step_ready, 1'b1);
    @(negedge clk); n = cyc; rf = 1'b0;
    wait_cyc(n + 2); check("R4 reg recover", bridge_en, 1'b1);

    // sleep
    @(negedge clk); n = cyc; sleep_n = 1'b0;
    wait_cyc(n + 2); check("R6 ready before", step_ready, 1'b1);
    wait_cyc(n + 3);
    check("R6 ready off", step_ready, 1'b0);
    check("R6 analog off", analog_off, 1'b1);
    check("R6 bridge off", bridge_en, 1'b0);
    send_step(0, "R6 drop asleep");

    // exit, re-sleep during wake, exit again
    @(negedge clk); n = cyc; sleep_n = 1'b1; push(0, n + 3, "R7 home on wake");
    wait_cyc(n + 20);
    @(negedge clk); m = cyc; sleep_n = 1'b0;
    wait_cyc(m + 3); check("R9 back asleep", analog_off, 1'b1);
    tick(5);
    @(negedge clk); n = cyc; sleep_n = 1'b1; push(0, n + 3, "R9 home again");
    wait_cyc(n + 2 + W); check("R9 ready early", step_ready, 1'b0);
    wait_cyc(n + 3 + W); check("R9 ready full delay", step_ready, 1'b1);

    // lockout while running
    @(negedge clk); n = cyc; uvlo = 1'b1;
    wait_cyc(n + 3);
    check("R5 relock analog", analog_off, 1'b1);
    check("R5 relock bridge", bridge_en, 1'b0);
    check("R5 relock ready", step_ready, 1'b0);
    @(negedge clk); n = cyc; uvlo = 1'b0; push(0, n + 3, "R5 home relock");
    wait_cyc(n + 3 + W); check("R5 ready after relock", step_ready, 1'b1);
    send_step(1, "R8 final pass");

    tick(5);
    while (exp_q.size() > 0) begin
      ev_t e;
      e = exp_q.pop_front();
      checks++; failures++;
      $display("FAIL %s: got nothing expected kind %0d at %0d", e.req, e.kind, e.at);
    end
    finish_run();
  end

endmodule